// File: doc/BRIEF.md
# Serial EEPROM I2C Target Controller

This block is the command engine of a byte-addressed serial memory that sits on an I2C bus as a target. A bus front-end has already turned SCL and SDA into single-cycle event strobes: start, stop, SCL rising (with the sampled SDA level) and SCL falling. From those strobes the controller assembles bytes most significant bit first. It checks the target address against three strap inputs and loads a two-byte word address into its internal pointer. Write data goes to a page-buffer byte port, and read data is fetched from a synchronous memory read port. The controller decides, for every byte, whether to pull SDA low on the ninth clock.

Writes end with a commit pulse that starts the internal programming cycle. That cycle is outside this block and is reported back on a busy input. While busy is high the controller refuses its own address, so a master can poll with headers until it gets an acknowledge. A write-protect input lets the address phase complete but refuses every data byte. Reads run from the pointer: current-address, random (a write header carrying only the word address, then a repeated start), and sequential with wrap-around.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A header byte is acknowledged only when its upper seven bits equal 1010 followed by strap_sel[2], strap_sel[1], strap_sel[0]. Bit 0 of the header selects read (1) or write (0). On a mismatch the header is not acknowledged and every later byte is ignored and not acknowledged until the next start or stop.
- R2: While wr_busy is high, a matching header is not acknowledged.
- R3: After a write header, the next two bytes form the word address, high byte first. High-byte bits above the array width are ignored (bits 7..5 at 8192 bytes; bits 7..4 at 4096 bytes). Each acknowledged data byte is written to the page buffer at the pointer.
- R4: During a write, the pointer advances only in its low five bits (32-byte page) and wraps inside the page. The page base bits stay unchanged.
- R5: With wr_protect high, the header and both word-address bytes are acknowledged, and the pointer is loaded. The first data byte is not acknowledged and is not written, and no commit follows.
- R6: A stop after at least one acknowledged data byte pulses pb_commit for one cycle. A stop after only an address phase does not pulse it. A repeated start discards the pending write, so a later stop does not commit it.
- R7: A read header without a preceding address phase returns the byte at the pointer. The pointer holds the last accessed address plus one.
- R8: After a random read (write header, word address, repeated start, read header), the first byte returned is the one at the loaded word address.
- R9: In a read, an acknowledge from the master (SDA low on the ninth clock) makes the controller send the next byte. The read address wraps from the top of the array to zero.
- R10: A missing master acknowledge (SDA high on the ninth clock) releases SDA. After that no more bytes are sent and no memory reads are issued until a start or stop.
- R11: sda_pull high means SDA is driven low. It changes only on a fall, start or stop strobe. An acknowledge is driven from the fall after the eighth bit until the fall after the ninth. After reset, sda_pull is low.
- R12: A start strobe in the middle of a byte aborts the transfer and restarts header reception. A stop strobe in the middle of a byte returns the controller to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_sel | input | 3 | Device select straps compared with header bits 3..1 |
| wr_protect | input | 1 | High refuses all data bytes of writes |
| wr_busy | input | 1 | High while the internal programming cycle runs |
| ev_start | input | 1 | Start condition strobe |
| ev_stop | input | 1 | Stop condition strobe |
| ev_rise | input | 1 | SCL rising strobe, SDA sampled in sda_bit |
| ev_fall | input | 1 | SCL falling strobe, time to change SDA |
| sda_bit | input | 1 | SDA level sampled at the rise |
| sda_pull | output | 1 | 1 pulls SDA low |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the request |
| pb_wr_en | output | 1 | Page-buffer byte write |
| pb_wr_addr | output | AW | Page-buffer byte address |
| pb_wr_data | output | 8 | Page-buffer byte data |
| pb_commit | output | 1 | One-cycle pulse that starts the programming cycle |

## Verification
Two functions share the rise strobe of the acknowledge slot in a read. Sampling the master's acknowledge and launching the prefetch of the next byte happen in the same cycle, and the pointer increments there too. The prefetched byte must reach the transmit register before the following fall drives its first bit. This is provoked with a sequential read that starts two bytes below the top of the array and crosses the wrap to zero. It is judged by comparing every reassembled byte with the bench's address-derived memory pattern.

// File: rtl/eit_pkg.sv
package eit_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_SKIP
  } eit_state_t;
endpackage

// File: rtl/eit_rx_shift.sv
module eit_rx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] sh
);
  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else if (en) sh <= {sh[W-2:0], din};
  end
endmodule

// File: rtl/eit_dev_match.sv
module eit_dev_match #(
  parameter logic [3:0] FAMILY = 4'b1010
) (
  input  logic [6:0] hdr,
  input  logic [2:0] strap,
  output logic       hit
);
  always_comb hit = (hdr == {FAMILY, strap});
endmodule

// File: rtl/eit_word_ptr.sv
module eit_word_ptr #(
  parameter int AW = 13,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc_page,
  input  logic          inc_seq,
  output logic [AW-1:0] ptr
);
  logic [PW-1:0] lo_nx;
  always_comb lo_nx = ptr[PW-1:0] + PW'(1);

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc_page) ptr <= {ptr[AW-1:PW], lo_nx};
    else if (inc_seq) ptr <= ptr + AW'(1);
  end
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target #(
  parameter int MEM_BYTES  = 8192,
  parameter int PAGE_BYTES = 32,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    strap_sel,
  input  logic          wr_protect,
  input  logic          wr_busy,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ev_rise,
  input  logic          ev_fall,
  input  logic          sda_bit,
  output logic          sda_pull,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [7:0]    mem_rd_data,
  output logic          pb_wr_en,
  output logic [AW-1:0] pb_wr_addr,
  output logic [7:0]    pb_wr_data,
  output logic          pb_commit
);
  import eit_pkg::*;

  eit_state_t    state;
  logic [3:0]    cnt;
  logic          ack_pend;
  logic          wr_any;
  logic          rd_q;
  logic [7:0]    tx;
  logic [AW-9:0] hi_q;
  logic [7:0]    sh;
  logic [7:0]    rx_byte;
  logic          hit;
  logic          rise_ok, active, byte_done, slot_end;
  logic          ptr_load, ptr_inc_page, ptr_inc_seq, rd_issue, wr_accept;
  logic [AW-1:0] ptr;
  logic [3:0]    tx_idx;

  always_comb begin
    rise_ok   = ev_rise && !ev_start && !ev_stop;
    active    = (state != ST_IDLE) && (state != ST_SKIP);
    byte_done = rise_ok && active && (cnt == 4'd7);
    slot_end  = rise_ok && active && (cnt == 4'd8);
    rx_byte   = {sh[6:0], sda_bit};
    tx_idx    = 4'd7 - cnt;
    wr_accept    = byte_done && (state == ST_WDAT) && !wr_protect;
    ptr_load     = byte_done && (state == ST_ALO);
    ptr_inc_page = wr_accept;
    rd_issue = (byte_done && (state == ST_DEV) && hit && !wr_busy && rx_byte[0]) ||
               (slot_end && (state == ST_RDAT) && !ack_pend && !sda_bit);
    ptr_inc_seq = rd_issue;
  end

  eit_rx_shift #(.W(8)) u_shift (
    .clk(clk), .rst(rst), .en(rise_ok && active && (cnt < 4'd8)),
    .din(sda_bit), .sh(sh)
  );

  eit_dev_match u_match (.hdr(rx_byte[7:1]), .strap(strap_sel), .hit(hit));

  eit_word_ptr #(.AW(AW), .PW(PW)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val({hi_q, rx_byte}),
    .inc_page(ptr_inc_page), .inc_seq(ptr_inc_seq), .ptr(ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      ack_pend    <= 1'b0;
      wr_any      <= 1'b0;
      rd_q        <= 1'b0;
      tx          <= '0;
      hi_q        <= '0;
      sda_pull    <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      pb_wr_en    <= 1'b0;
      pb_wr_addr  <= '0;
      pb_wr_data  <= '0;
      pb_commit   <= 1'b0;
    end else begin
      mem_rd_en <= 1'b0;
      pb_wr_en  <= 1'b0;
      pb_commit <= 1'b0;
      rd_q      <= mem_rd_en;
      if (rd_q) tx <= mem_rd_data;

      if (ev_stop) begin
        pb_commit <= wr_any;
        state     <= ST_IDLE;
        cnt       <= '0;
        ack_pend  <= 1'b0;
        wr_any    <= 1'b0;
        sda_pull  <= 1'b0;
      end else if (ev_start) begin
        state    <= ST_DEV;
        cnt      <= '0;
        ack_pend <= 1'b0;
        wr_any   <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        if (slot_end) begin
          cnt      <= '0;
          ack_pend <= 1'b0;
          if ((state == ST_RDAT) && !ack_pend && sda_bit) state <= ST_SKIP;
        end else if (rise_ok && active) begin
          cnt <= cnt + 4'd1;
          if (byte_done) begin
            case (state)
              ST_DEV: begin
                if (hit && !wr_busy) begin
                  ack_pend <= 1'b1;
                  state    <= rx_byte[0] ? ST_RDAT : ST_AHI;
                end else begin
                  state <= ST_SKIP;
                end
              end
              ST_AHI: begin
                hi_q     <= rx_byte[AW-9:0];
                ack_pend <= 1'b1;
                state    <= ST_ALO;
              end
              ST_ALO: begin
                ack_pend <= 1'b1;
                state    <= ST_WDAT;
              end
              ST_WDAT: begin
                if (wr_accept) begin
                  pb_wr_en   <= 1'b1;
                  pb_wr_addr <= ptr;
                  pb_wr_data <= rx_byte;
                  wr_any     <= 1'b1;
                  ack_pend   <= 1'b1;
                end else begin
                  state <= ST_SKIP;
                end
              end
              default: ;
            endcase
          end
        end

        if (rd_issue) begin
          mem_rd_en   <= 1'b1;
          mem_rd_addr <= ptr;
        end

        if (ev_fall) begin
          if (!active) sda_pull <= 1'b0;
          else if (cnt == 4'd8) sda_pull <= ack_pend;
          else if (state == ST_RDAT) sda_pull <= ~tx[tx_idx[2:0]];
          else sda_pull <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/eit_checker.sv
module eit_checker (
  input logic clk,
  input logic rst,
  input logic wr_protect,
  input logic ev_start,
  input logic ev_stop,
  input logic ev_fall,
  input logic sda_pull,
  input logic mem_rd_en,
  input logic pb_wr_en,
  input logic pb_commit
);
  // R5: no page-buffer write while protected
  p_no_wr_protected_r5: assert property (@(posedge clk) disable iff (rst)
    pb_wr_en |-> !$past(wr_protect));

  // R6: commit only right after a stop
  p_commit_after_stop_r6: assert property (@(posedge clk) disable iff (rst)
    pb_commit |-> $past(ev_stop));

  // R11: SDA released after start or stop
  p_release_on_frame_r11: assert property (@(posedge clk) disable iff (rst)
    (ev_start || ev_stop) |=> !sda_pull);

  // R11: SDA drive changes only on fall, start or stop strobes
  p_drive_on_fall_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> $past(ev_fall || ev_start || ev_stop));

  // R3: memory read and buffer write never in the same cycle
  p_rd_wr_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && pb_wr_en));
endmodule

bind eeprom_i2c_target eit_checker i_eit_checker (
  .clk(clk), .rst(rst), .wr_protect(wr_protect), .ev_start(ev_start),
  .ev_stop(ev_stop), .ev_fall(ev_fall), .sda_pull(sda_pull),
  .mem_rd_en(mem_rd_en), .pb_wr_en(pb_wr_en), .pb_commit(pb_commit)
);

// File: tb/test_eeprom_i2c_target.sv
`timescale 1ns/1ps
module test_eeprom_i2c_target;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    strap_sel = 3'b101;
  logic          wr_protect = 1'b0;
  logic          wr_busy = 1'b0;
  logic          ev_start = 1'b0, ev_stop = 1'b0, ev_rise = 1'b0, ev_fall = 1'b0;
  logic          sda_bit = 1'b1;
  logic          sda_pull;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [7:0]    mem_rd_data;
  logic          pb_wr_en;
  logic [AW-1:0] pb_wr_addr;
  logic [7:0]    pb_wr_data;
  logic          pb_commit;

  int tests = 0, fails = 0;
  int pb_n = 0, commits = 0, reads = 0;
  logic [AW-1:0] lg_a [0:63];
  logic [7:0]    lg_d [0:63];

  always #2.5 clk = ~clk;

  eeprom_i2c_target i_eeprom_i2c_target (
    .clk(clk), .rst(rst), .strap_sel(strap_sel), .wr_protect(wr_protect),
    .wr_busy(wr_busy), .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise),
    .ev_fall(ev_fall), .sda_bit(sda_bit), .sda_pull(sda_pull),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .pb_wr_en(pb_wr_en), .pb_wr_addr(pb_wr_addr), .pb_wr_data(pb_wr_data),
    .pb_commit(pb_commit)
  );

  function automatic logic [7:0] fmem(input logic [AW-1:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= fmem(mem_rd_addr);
      reads <= reads + 1;
    end
    if (pb_wr_en && pb_n < 64) begin
      lg_a[pb_n] <= pb_wr_addr;
      lg_d[pb_n] <= pb_wr_data;
      pb_n <= pb_n + 1;
    end
    if (pb_commit) commits <= commits + 1;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start(); pulse(ev_start); endtask
  task automatic bus_stop();  pulse(ev_stop);  endtask

  task automatic clk_bit(input logic b);
    sda_bit = b;
    pulse(ev_rise);
    pulse(ev_fall);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    ack = sda_pull;
    clk_bit(!ack);
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic mack);
    for (int i = 7; i >= 0; i--) begin
      d[i] = !sda_pull;
      clk_bit(d[i]);
    end
    chk(sda_pull == 1'b0, "R11 read ack slot released", sda_pull, 0);
    clk_bit(!mack);
  endtask

  task automatic t_reset();
    chk(sda_pull == 0 && pb_wr_en == 0 && mem_rd_en == 0 && pb_commit == 0,
        "R11 reset state", {sda_pull, pb_wr_en, mem_rd_en, pb_commit}, 0);
  endtask

  task automatic t_ack_timing();
    logic a;
    bus_start();
    for (int i = 7; i >= 1; i--) clk_bit(8'hAA >> i);
    sda_bit = 1'b0;
    pulse(ev_rise);
    chk(sda_pull == 0, "R11 no ack before eighth fall", sda_pull, 0);
    pulse(ev_fall);
    chk(sda_pull == 1, "R11 ack after eighth fall", sda_pull, 1);
    sda_bit = 1'b0;
    pulse(ev_rise);
    chk(sda_pull == 1, "R11 ack held over ninth rise", sda_pull, 1);
    pulse(ev_fall);
    chk(sda_pull == 0, "R11 released after ninth fall", sda_pull, 0);
    wr_byte(8'h00, a);
    bus_stop();
    chk(commits == 0, "R6 no commit after address only", commits, 0);
  endtask

  task automatic t_byte_write();
    logic a0, a1, a2, a3;
    int n0 = pb_n, c0 = commits;
    bus_start();
    wr_byte(8'hAA, a0);
    wr_byte(8'hE1, a1);
    wr_byte(8'h23, a2);
    wr_byte(8'h5A, a3);
    bus_stop();
    repeat (2) @(negedge clk);
    chk(a0 && a1 && a2 && a3, "R1 header and bytes acked", {a0, a1, a2, a3}, 4'hF);
    chk(pb_n == n0 + 1 && lg_a[n0] == 13'h0123 && lg_d[n0] == 8'h5A,
        "R3 write addr/data", {lg_a[n0], lg_d[n0]}, {13'h0123, 8'h5A});
    chk(commits == c0 + 1, "R6 commit on stop", commits, c0 + 1);
  endtask

  task automatic t_mismatch();
    logic a0, a1;
    int n0 = pb_n;
    bus_start();
    wr_byte(8'hA8, a0);
    wr_byte(8'h00, a1);
    bus_stop();
    chk(!a0 && !a1, "R1 mismatch not acked", {a0, a1}, 0);
    chk(pb_n == n0, "R1 mismatch no write", pb_n, n0);
  endtask

  task automatic t_busy();
    logic a0, a1;
    wr_busy = 1'b1;
    bus_start();
    wr_byte(8'hAA, a0);
    bus_stop();
    wr_busy = 1'b0;
    bus_start();
    wr_byte(8'hAA, a1);
    bus_stop();
    chk(!a0, "R2 busy header nacked", a0, 0);
    chk(a1, "R2 idle header acked", a1, 1);
  endtask

  task automatic t_page();
    logic a;
    int n0 = pb_n;
    bus_start();
    wr_byte(8'hAA, a);
    wr_byte(8'h00, a);
    wr_byte(8'h3E, a);
    wr_byte(8'h11, a);
    wr_byte(8'h22, a);
    wr_byte(8'h33, a);
    bus_stop();
    repeat (2) @(negedge clk);
    chk(pb_n == n0 + 3, "R4 three bytes written", pb_n, n0 + 3);
    chk(lg_a[n0] == 13'h3E && lg_a[n0+1] == 13'h3F && lg_a[n0+2] == 13'h20,
        "R4 page wrap", lg_a[n0+2], 13'h20);
    chk(lg_d[n0+2] == 8'h33, "R4 wrapped data", lg_d[n0+2], 8'h33);
  endtask

  task automatic t_current_read();
    logic a;
    logic [7:0] d;
    int r0;
    bus_start();
    wr_byte(8'hAB, a);
    rd_byte(d, 1'b0);
    chk(a, "R7 read header acked", a, 1);
    chk(d == fmem(13'h0021), "R7 current address data", d, fmem(13'h0021));
    r0 = reads;
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1);
      chk(sda_pull == 0, "R10 released after nack", sda_pull, 0);
    end
    chk(reads == r0, "R10 no reads after nack", reads, r0);
    bus_stop();
  endtask

  task automatic t_random_seq();
    logic a;
    logic [7:0] d0, d1, d2;
    bus_start();
    wr_byte(8'hAA, a);
    wr_byte(8'h1F, a);
    wr_byte(8'hFE, a);
    bus_start();
    wr_byte(8'hAB, a);
    rd_byte(d0, 1'b1);
    rd_byte(d1, 1'b1);
    rd_byte(d2, 1'b0);
    bus_stop();
    chk(d0 == fmem(13'h1FFE), "R8 random read data", d0, fmem(13'h1FFE));
    chk(d1 == fmem(13'h1FFF), "R9 sequential next", d1, fmem(13'h1FFF));
    chk(d2 == fmem(13'h0000), "R9 wrap to zero", d2, fmem(13'h0000));
  endtask

  task automatic t_protect();
    logic a0, a1, a2, a3;
    logic [7:0] d;
    int n0 = pb_n, c0 = commits;
    wr_protect = 1'b1;
    bus_start();
    wr_byte(8'hAA, a0);
    wr_byte(8'h01, a1);
    wr_byte(8'h55, a2);
    wr_byte(8'h77, a3);
    bus_stop();
    repeat (2) @(negedge clk);
    wr_protect = 1'b0;
    chk(a0 && a1 && a2, "R5 address phase acked", {a0, a1, a2}, 3'h7);
    chk(!a3, "R5 data nacked", a3, 0);
    chk(pb_n == n0 && commits == c0, "R5 no write no commit", pb_n - n0, 0);
    bus_start();
    wr_byte(8'hAB, a0);
    rd_byte(d, 1'b0);
    bus_stop();
    chk(d == fmem(13'h0155), "R5 pointer loaded", d, fmem(13'h0155));
  endtask

  task automatic t_rstart_discard();
    logic a;
    int c0 = commits;
    bus_start();
    wr_byte(8'hAA, a);
    wr_byte(8'h00, a);
    wr_byte(8'h40, a);
    wr_byte(8'h99, a);
    bus_start();
    bus_stop();
    repeat (2) @(negedge clk);
    chk(commits == c0, "R6 repeated start discards", commits, c0);
  endtask

  task automatic t_abort();
    logic a;
    bus_start();
    wr_byte(8'hAA, a);
    for (int i = 0; i < 4; i++) clk_bit(1'b1);
    bus_start();
    wr_byte(8'hAA, a);
    chk(a, "R12 start mid-byte restarts header", a, 1);
    for (int i = 0; i < 3; i++) clk_bit(1'b0);
    bus_stop();
    chk(sda_pull == 0, "R12 stop mid-byte releases", sda_pull, 0);
    for (int i = 7; i >= 0; i--) clk_bit(8'hAA >> i);
    chk(sda_pull == 0, "R12 idle ignores bits", sda_pull, 0);
    clk_bit(1'b1);
    bus_start();
    wr_byte(8'hAA, a);
    bus_stop();
    chk(a, "R12 header after stop acked", a, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_ack_timing();
    t_byte_write();
    t_mismatch();
    t_busy();
    t_page();
    t_current_read();
    t_random_seq();
    t_protect();
    t_rstart_discard();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule